// File: doc/BRIEF.md
# Programmable SCL Timing Generator

This block produces the serial clock for a two-wire bus master. It counts cycles of a fixed oscillator and splits each SCL period into a low phase and a high phase. The low phase and the high phase each have their own count. The byte engine receives a strobe at every falling and every rising SCL edge, so it can move SDA at the correct point in each bit.

Software reaches the block through a small host port. Address 0 holds a control byte. Address 1 holds an index pointer. Address 2 is a data window onto the indirect entry that the pointer selects. The control byte turns the generator on. It can also switch from the programmed counts to one of eight fixed legacy rates. After the generator is turned on, a settling delay passes before the ready flag rises and SCL starts to toggle. A two-byte key written to a dedicated indirect entry resets the whole controller.

During the high phase the block counts only while the bus line actually reads high. A slave that holds SCL low therefore stretches the period.

Top module: `scl_timing_gen`

## Requirements
- R1: A write to host address 1 sets the index pointer (bits 2:0). Reads and writes at address 2 reach the selected entry: 0 own address, 1 timeout, 2 bus mode, 3 low count, 4 high count. Each of these entries reads back the last value written. Index 5 (the key entry) and indices 6 and 7 read as 0. The pointer itself reads back at address 1.
- R2: Host address 0 is the control byte: bit 6 enable, bit 3 legacy-rate select, bits 2:0 legacy rate code. It reads back with all other bits 0.
- R3: The bus-mode entry keeps 2 bits (0 standard, 1 fast, 2 fast-plus, 3 turbo). The value appears on `busMode`, and the upper bits read as 0.
- R4: When running with legacy select off, `sclDriveLow` stays asserted for exactly low-count cycles. It is then released for exactly high-count cycles while `sclIn` stays high, so one period is low + high cycles.
- R5: During the high phase the count advances only in cycles where `sclIn` is high. Each cycle in which a slave holds the line low lengthens the period by one cycle.
- R6: A low or high count of 0 acts as 1, so the zero/zero setting gives a period of 2 cycles.
- R7: With legacy select on, both phases last floor(OSC_KHZ / (2 * rate)) cycles. The rate is taken from the code: 0→330, 1→288, 2→217, 3→146, 4→88, 5→59, 6→44, 7→36 kHz.
- R8: `ready` rises SETTLE_TICKS cycles after the enable bit is written to 1. It falls one cycle after enable reads 0. While `ready` is low, SCL is released.
- R9: `fallTick` is a one-cycle pulse in the first cycle of every low phase. `riseTick` is a one-cycle pulse in the first cycle of every high phase. The first low phase starts one cycle after `ready` rises.
- R10: With the pointer at 5, a data-port write of 0xA5 followed by a data-port write of 0x5A pulses `ctrlReset` for one cycle. All registers then return to 0, and `ready` falls. A 0xA5 written with any other pointer value does not arm the sequence.
- R11: After 0xA5, the next data-port write cancels the sequence when it is anything other than 0x5A at index 5. No reset happens, and a later 0x5A alone does not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 2 | Host address: 0 control, 1 pointer, 2 data window |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data (combinational from address) |
| sclIn | input | 1 | Sensed level of the SCL line |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| fallTick | output | 1 | Strobe at start of each low phase |
| riseTick | output | 1 | Strobe at start of each high phase |
| ready | output | 1 | Settling delay done, clock running |
| busMode | output | 2 | Selected bus speed class |
| ctrlReset | output | 1 | One-cycle controller reset pulse |

## Verification
A wrong phase counter first appears as an SCL edge that arrives one or more cycles early or late. The per-cycle reference model catches it on the first edge that moves, and the `fallTick`/`riseTick` strobes then also fall out of step. A broken stretch gate shows as a high phase that ends while the line is still held. A faulty key sequencer shows as a `ctrlReset` pulse that appears or goes missing, and the registers read back after the sequence give the same evidence. A settle counter that is off by any amount moves the `ready` edge, and the first falling SCL edge moves with it.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 3;

  // host address map
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PTR  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // indirect entries
  localparam logic [PTR_W-1:0] IDX_OWN  = 3'd0;
  localparam logic [PTR_W-1:0] IDX_TMO  = 3'd1;
  localparam logic [PTR_W-1:0] IDX_MODE = 3'd2;
  localparam logic [PTR_W-1:0] IDX_LOW  = 3'd3;
  localparam logic [PTR_W-1:0] IDX_HIGH = 3'd4;
  localparam logic [PTR_W-1:0] IDX_KEY  = 3'd5;

  // control byte fields
  localparam int CTRL_EN_BIT  = 6;
  localparam int CTRL_LEG_BIT = 3;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h4F;

  localparam logic [BYTE_W-1:0] KEY_ARM  = 8'hA5;
  localparam logic [BYTE_W-1:0] KEY_FIRE = 8'h5A;

  typedef enum logic [1:0] {
    MODE_STD   = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_FASTP = 2'd2,
    MODE_TURBO = 2'd3
  } bus_mode_e;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

  // command from control to phase datapath
  typedef struct packed {
    logic              run;
    logic [BYTE_W-1:0] lowTicks;
    logic [BYTE_W-1:0] highTicks;
  } phase_cmd_t;
endpackage

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pkg::*;
#(
  parameter int OSC_KHZ      = 6600,
  parameter int SETTLE_TICKS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [1:0]        hostAddr,
  input  logic [BYTE_W-1:0] hostWdata,
  output logic [BYTE_W-1:0] hostRdata,
  output phase_cmd_t        cmd,
  output logic [1:0]        busMode,
  output logic              ctrlReset
);
  localparam int SETTLE_W = $clog2(SETTLE_TICKS + 1);
  localparam int LEG_CODES = 8;

  function automatic int rateKhz(input int code);
    case (code)
      0:       return 330;
      1:       return 288;
      2:       return 217;
      3:       return 146;
      4:       return 88;
      5:       return 59;
      6:       return 44;
      default: return 36;
    endcase
  endfunction

  logic [BYTE_W-1:0] ctrlReg;
  logic [PTR_W-1:0]  ptrReg;
  logic [BYTE_W-1:0] ownReg;
  logic [BYTE_W-1:0] tmoReg;
  logic [1:0]        modeReg;
  logic [BYTE_W-1:0] lowReg;
  logic [BYTE_W-1:0] highReg;
  key_state_e        keyState;
  logic              softRstQ;
  logic [SETTLE_W-1:0] settleCnt;
  logic              readyQ;

  // legacy half-period table, computed from oscillator rate
  logic [BYTE_W-1:0] legHalf [LEG_CODES];
  for (genvar i = 0; i < LEG_CODES; i++) begin : g_leg
    localparam int HALF = OSC_KHZ / (2 * rateKhz(i));
    localparam int SAT  = (HALF > 255) ? 255 : HALF;
    assign legHalf[i] = BYTE_W'(SAT);
  end

  wire enableBit = ctrlReg[CTRL_EN_BIT];
  wire legacyBit = ctrlReg[CTRL_LEG_BIT];
  wire dataWr    = hostWe && (hostAddr == ADDR_DATA);

  // register file, key sequencer, settle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      ptrReg    <= '0;
      ownReg    <= '0;
      tmoReg    <= '0;
      modeReg   <= '0;
      lowReg    <= '0;
      highReg   <= '0;
      keyState  <= KEY_IDLE;
      softRstQ  <= 1'b0;
      settleCnt <= '0;
      readyQ    <= 1'b0;
    end else if (softRstQ) begin
      ctrlReg   <= '0;
      ptrReg    <= '0;
      ownReg    <= '0;
      tmoReg    <= '0;
      modeReg   <= '0;
      lowReg    <= '0;
      highReg   <= '0;
      keyState  <= KEY_IDLE;
      softRstQ  <= 1'b0;
      settleCnt <= '0;
      readyQ    <= 1'b0;
    end else begin
      softRstQ <= 1'b0;
      if (hostWe && hostAddr == ADDR_CTRL) ctrlReg <= hostWdata & CTRL_MASK;
      if (hostWe && hostAddr == ADDR_PTR)  ptrReg  <= hostWdata[PTR_W-1:0];
      if (dataWr) begin
        case (ptrReg)
          IDX_OWN:  ownReg  <= hostWdata;
          IDX_TMO:  tmoReg  <= hostWdata;
          IDX_MODE: modeReg <= hostWdata[1:0];
          IDX_LOW:  lowReg  <= hostWdata;
          IDX_HIGH: highReg <= hostWdata;
          default:  ;
        endcase
        if (keyState == KEY_ARMED) begin
          keyState <= KEY_IDLE;
          if (ptrReg == IDX_KEY && hostWdata == KEY_FIRE) softRstQ <= 1'b1;
        end else if (ptrReg == IDX_KEY && hostWdata == KEY_ARM) begin
          keyState <= KEY_ARMED;
        end
      end
      if (!enableBit) begin
        settleCnt <= '0;
        readyQ    <= 1'b0;
      end else if (!readyQ) begin
        if (settleCnt == SETTLE_W'(SETTLE_TICKS - 1)) readyQ <= 1'b1;
        else settleCnt <= settleCnt + 1'b1;
      end
    end
  end

  // host read mux
  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      ADDR_CTRL: hostRdata = ctrlReg;
      ADDR_PTR:  hostRdata = BYTE_W'(ptrReg);
      ADDR_DATA: begin
        case (ptrReg)
          IDX_OWN:  hostRdata = ownReg;
          IDX_TMO:  hostRdata = tmoReg;
          IDX_MODE: hostRdata = BYTE_W'(modeReg);
          IDX_LOW:  hostRdata = lowReg;
          IDX_HIGH: hostRdata = highReg;
          default:  hostRdata = '0;
        endcase
      end
      default: hostRdata = '0;
    endcase
  end

  // effective counts handed to the datapath
  logic [BYTE_W-1:0] lowSel, highSel;
  always_comb begin
    lowSel        = legacyBit ? legHalf[ctrlReg[2:0]] : lowReg;
    highSel       = legacyBit ? legHalf[ctrlReg[2:0]] : highReg;
    cmd.run       = readyQ;
    cmd.lowTicks  = (lowSel == '0) ? BYTE_W'(1) : lowSel;
    cmd.highTicks = (highSel == '0) ? BYTE_W'(1) : highSel;
  end

  assign busMode   = modeReg;
  assign ctrlReset = softRstQ;

  AST_ENABLE_GATES_READY: assert property (@(posedge clk) disable iff (!rstN)
    !enableBit |=> !readyQ); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReset |=> (ctrlReg == '0 && ptrReg == '0 && ownReg == '0 && !readyQ)); // R10
  AST_RESET_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReset |=> !ctrlReset); // R10
  AST_KEY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRstQ) |-> $past(keyState == KEY_ARMED)); // R11
endmodule

// File: rtl/scl_phase.sv
module scl_phase
  import scl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  phase_cmd_t cmd,
  input  logic       sclIn,
  output logic       sclDriveLow,
  output logic       fallTick,
  output logic       riseTick
);
  logic              running;
  logic              phaseHigh;
  logic [BYTE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      phaseHigh <= 1'b1;
      cnt       <= '0;
      fallTick  <= 1'b0;
      riseTick  <= 1'b0;
    end else begin
      fallTick <= 1'b0;
      riseTick <= 1'b0;
      if (!cmd.run) begin
        running   <= 1'b0;
        phaseHigh <= 1'b1;
        cnt       <= '0;
      end else if (!running) begin
        running   <= 1'b1;
        phaseHigh <= 1'b0;
        cnt       <= BYTE_W'(1);
        fallTick  <= 1'b1;
      end else if (!phaseHigh) begin
        if (cnt >= cmd.lowTicks) begin
          phaseHigh <= 1'b1;
          cnt       <= BYTE_W'(1);
          riseTick  <= 1'b1;
        end else begin
          cnt <= cnt + BYTE_W'(1);
        end
      end else if (sclIn) begin
        if (cnt >= cmd.highTicks) begin
          phaseHigh <= 1'b0;
          cnt       <= BYTE_W'(1);
          fallTick  <= 1'b1;
        end else begin
          cnt <= cnt + BYTE_W'(1);
        end
      end
    end
  end

  assign sclDriveLow = running && !phaseHigh;

  AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(fallTick && riseTick)); // R9
  AST_FALL_WITH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    fallTick |-> sclDriveLow); // R9
  AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    riseTick |-> !sclDriveLow); // R9
  AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (running && phaseHigh && !sclIn && cmd.run) |=> (phaseHigh && $stable(cnt))); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> !sclDriveLow); // R8
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_pkg::*;
#(
  parameter int OSC_KHZ      = 6600,
  parameter int SETTLE_TICKS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWe,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic       sclIn,
  output logic       sclDriveLow,
  output logic       fallTick,
  output logic       riseTick,
  output logic       ready,
  output logic [1:0] busMode,
  output logic       ctrlReset
);
  phase_cmd_t cmd;

  scl_ctrl #(
    .OSC_KHZ     (OSC_KHZ),
    .SETTLE_TICKS(SETTLE_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .cmd      (cmd),
    .busMode  (busMode),
    .ctrlReset(ctrlReset)
  );

  scl_phase u_phase (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .sclIn      (sclIn),
    .sclDriveLow(sclDriveLow),
    .fallTick   (fallTick),
    .riseTick   (riseTick)
  );

  assign ready = cmd.run;
endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  localparam int OSC_KHZ = 6600;
  localparam int SETTLE  = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       hostWe = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWdata = 8'd0;
  logic [7:0] hostRdata;
  logic       slaveHold = 1'b0;
  logic       sclIn;
  logic       sclDriveLow, fallTick, riseTick, ready, ctrlReset;
  logic [1:0] busMode;

  assign sclIn = ~sclDriveLow & ~slaveHold;

  scl_timing_gen #(.OSC_KHZ(OSC_KHZ), .SETTLE_TICKS(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .sclIn(sclIn),
    .sclDriveLow(sclDriveLow), .fallTick(fallTick), .riseTick(riseTick),
    .ready(ready), .busMode(busMode), .ctrlReset(ctrlReset)
  );

  int    checks = 0;
  int    fails = 0;
  int    rstPulses = 0;
  bit    done = 1'b0;
  string tag = "R8";

  task automatic check(input string t, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic int legHalf(input int code);
    int rates[8] = '{330, 288, 217, 146, 88, 59, 44, 36};
    int h = OSC_KHZ / (2 * rates[code]);
    return (h > 255) ? 255 : h;
  endfunction

  // reference model state
  logic [7:0] mCtrl, mOwn, mTmo, mLow, mHi;
  int mPtr, mMode, mArmed, mSoft, mSettle, mReady;
  int mRun, mPh, mCnt, mFall, mRise;

  always @(posedge clk) begin
    int lowE, highE, sIn, nRun, nPh, nCnt, nFall, nRise, oldEn;
    if (!rstN) begin
      mCtrl = 0; mOwn = 0; mTmo = 0; mLow = 0; mHi = 0;
      mPtr = 0; mMode = 0; mArmed = 0; mSoft = 0; mSettle = 0; mReady = 0;
      mRun = 0; mPh = 1; mCnt = 0; mFall = 0; mRise = 0;
    end else begin
      lowE  = mCtrl[3] ? legHalf(int'(mCtrl[2:0])) : int'(mLow);
      highE = mCtrl[3] ? legHalf(int'(mCtrl[2:0])) : int'(mHi);
      if (lowE == 0) lowE = 1;
      if (highE == 0) highE = 1;
      sIn = (!(mRun != 0 && mPh == 0) && !slaveHold) ? 1 : 0;
      nRun = mRun; nPh = mPh; nCnt = mCnt; nFall = 0; nRise = 0;
      if (mReady == 0) begin
        nRun = 0; nPh = 1; nCnt = 0;
      end else if (mRun == 0) begin
        nRun = 1; nPh = 0; nCnt = 1; nFall = 1;
      end else if (mPh == 0) begin
        if (mCnt >= lowE) begin nPh = 1; nCnt = 1; nRise = 1; end
        else nCnt = mCnt + 1;
      end else if (sIn != 0) begin
        if (mCnt >= highE) begin nPh = 0; nCnt = 1; nFall = 1; end
        else nCnt = mCnt + 1;
      end
      if (mSoft != 0) begin
        mCtrl = 0; mOwn = 0; mTmo = 0; mLow = 0; mHi = 0;
        mPtr = 0; mMode = 0; mArmed = 0; mSoft = 0; mSettle = 0; mReady = 0;
      end else begin
        mSoft = 0;
        oldEn = mCtrl[6];
        if (hostWe) begin
          case (hostAddr)
            2'd0: mCtrl = hostWdata & 8'h4F;
            2'd1: mPtr = hostWdata & 7;
            2'd2: begin
              case (mPtr)
                0: mOwn = hostWdata;
                1: mTmo = hostWdata;
                2: mMode = hostWdata & 3;
                3: mLow = hostWdata;
                4: mHi = hostWdata;
                default: ;
              endcase
              if (mArmed != 0) begin
                mArmed = 0;
                if (mPtr == 5 && hostWdata == 8'h5A) mSoft = 1;
              end else if (mPtr == 5 && hostWdata == 8'hA5) mArmed = 1;
            end
            default: ;
          endcase
        end
        if (oldEn == 0) begin mSettle = 0; mReady = 0; end
        else if (mReady == 0) begin
          if (mSettle == SETTLE - 1) mReady = 1;
          else mSettle++;
        end
      end
      mRun = nRun; mPh = nPh; mCnt = nCnt; mFall = nFall; mRise = nRise;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(tag, int'(sclDriveLow), (mRun != 0 && mPh == 0) ? 1 : 0, "sclDriveLow");
      check("R9", int'(fallTick), mFall, "fallTick");
      check("R9", int'(riseTick), mRise, "riseTick");
      check("R8", int'(ready), mReady, "ready");
      check("R10", int'(ctrlReset), mSoft, "ctrlReset");
      check("R3", int'(busMode), mMode, "busMode");
      if (ctrlReset) rstPulses++;
    end
  end

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic setInd(input logic [7:0] idx, input logic [7:0] val);
    hostWrite(2'd1, idx);
    hostWrite(2'd2, val);
  endtask

  task automatic hostRead(input logic [1:0] a, input int exp, input string t);
    @(negedge clk);
    hostAddr = a;
    #2;
    check(t, int'(hostRdata), exp, "read");
  endtask

  task automatic measurePeriod(input int exp, input string t);
    int n;
    do @(negedge clk); while (!fallTick);
    n = 0;
    do begin @(negedge clk); n++; end while (!fallTick);
    check(t, n, exp, "period");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    check("R2", int'(sclDriveLow), 0, "reset sclDriveLow");
    check("R8", int'(ready), 0, "reset ready");
    hostRead(2'd0, 0, "R2");
    hostRead(2'd1, 0, "R1");

    // indirect register file
    tag = "R1";
    setInd(8'd0, 8'h55);
    setInd(8'd1, 8'h3C);
    setInd(8'd2, 8'hFE);
    setInd(8'd3, 8'd4);
    setInd(8'd4, 8'd3);
    hostWrite(2'd1, 8'd0); hostRead(2'd2, 8'h55, "R1");
    hostWrite(2'd1, 8'd1); hostRead(2'd2, 8'h3C, "R1");
    hostRead(2'd1, 1, "R1");
    hostWrite(2'd1, 8'd2); hostRead(2'd2, 2, "R3");
    check("R3", int'(busMode), 2, "busMode");
    hostWrite(2'd1, 8'd3); hostRead(2'd2, 4, "R1");
    hostWrite(2'd1, 8'd4); hostRead(2'd2, 3, "R1");
    hostWrite(2'd1, 8'd6); hostRead(2'd2, 0, "R1");

    // control byte masking
    hostWrite(2'd0, 8'hB7); hostRead(2'd0, 8'h07, "R2");

    // enable and settle
    tag = "R8";
    hostWrite(2'd0, 8'h40);
    n = 0;
    while (!ready) begin @(negedge clk); n++; end
    check("R8", n, SETTLE, "settle cycles");
    @(negedge clk);
    check("R9", int'(sclDriveLow), 1, "first low after ready");

    // programmed timing
    tag = "R4";
    measurePeriod(7, "R4");
    measurePeriod(7, "R4");

    // clock stretching during high phase
    tag = "R5";
    do @(negedge clk); while (!riseTick);
    slaveHold = 1'b1;
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    slaveHold = 1'b0;
    do begin @(negedge clk); n++; end while (!fallTick);
    check("R5", n, 8, "stretched high");

    // zero counts act as one
    tag = "R6";
    setInd(8'd3, 8'd0);
    setInd(8'd4, 8'd0);
    measurePeriod(2, "R6");
    measurePeriod(2, "R6");

    // legacy rates
    tag = "R7";
    hostWrite(2'd0, 8'h48);
    measurePeriod(2 * legHalf(0), "R7");
    measurePeriod(20, "R7");
    hostWrite(2'd0, 8'h4B);
    measurePeriod(44, "R7");
    measurePeriod(44, "R7");
    hostWrite(2'd0, 8'h4F);
    measurePeriod(182, "R7");
    measurePeriod(182, "R7");

    // disable
    tag = "R8";
    hostWrite(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    check("R8", int'(ready), 0, "ready after disable");
    check("R8", int'(sclDriveLow), 0, "released after disable");

    // key-protected soft reset
    tag = "R10";
    setInd(8'd0, 8'h77);
    hostWrite(2'd0, 8'h40);
    repeat (SETTLE + 20) @(negedge clk);
    n = rstPulses;
    hostWrite(2'd1, 8'd5);
    hostWrite(2'd2, 8'hA5);
    hostWrite(2'd2, 8'h5A);
    repeat (4) @(negedge clk);
    check("R10", rstPulses - n, 1, "reset pulses");
    check("R10", int'(ready), 0, "ready after soft reset");
    hostRead(2'd0, 0, "R10");
    hostRead(2'd1, 0, "R10");
    hostRead(2'd2, 0, "R10");

    // cancelled and unarmed sequences
    tag = "R11";
    setInd(8'd0, 8'h66);
    n = rstPulses;
    hostWrite(2'd1, 8'd5);
    hostWrite(2'd2, 8'hA5);
    hostWrite(2'd2, 8'h11);
    hostWrite(2'd2, 8'h5A);
    setInd(8'd3, 8'hA5);
    hostWrite(2'd1, 8'd5);
    hostWrite(2'd2, 8'h5A);
    repeat (3) @(negedge clk);
    check("R11", rstPulses - n, 0, "no reset pulse");
    hostWrite(2'd1, 8'd0); hostRead(2'd2, 8'h66, "R11");
    hostWrite(2'd1, 8'd3); hostRead(2'd2, 8'hA5, "R10");

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule